// File: doc/BRIEF.md
# Vectored Prioritised Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor through two request lines: a fast line and a normal line. Each source is OR-combined with a request bit that software can raise, then gated by a per-source enable and steered by a per-source select bit to one of the two lines. Software reaches all of it through a word-addressed 32-bit register port. A read returns data in the same cycle. Any side effect of an access takes place at the next clock edge.

On the normal line, sixteen vector slots each bind one source number to a programmable handler address. Slot 0 has the highest priority. A read of the current-vector register returns the handler address of the best eligible slot and records that slot as in service on a nesting stack. Only slots with a strictly higher priority can then preempt it. A write of any value to the same register ends the innermost service. When no slot is eligible, the read returns a programmable default address and records nothing. Four identification registers expose a 32-bit cell code one byte at a time.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, both request lines are low, and a current-vector read returns 0.
- R2: The raw register (byte offset 0x08) reads the hardware source inputs ORed with the software request bits.
- R3: A select bit of 1 routes its source to the fast line and 0 to the normal line. Offset 0x00 reads raw & enable & ~select, and 0x04 reads raw & enable & select. `irq_out` is the OR of the first and `fiq_out` is the OR of the second.
- R4: Writing ones to 0x10 sets enable bits and writing ones to 0x14 clears them. Zero bits leave bits unchanged, and reading 0x10 returns the enable mask.
- R5: Writing ones to 0x18 sets software request bits and writing ones to 0x1C clears them. Zero bits leave bits unchanged, and reading 0x18 returns the request bits.
- R6: Slot n has its handler address at 0x100+4n and its control word at 0x200+4n. In the control word, bit 5 is the slot enable and bits 4:0 are the bound source number. Both registers read back what was written, with the control word limited to bits 5:0.
- R7: A read of 0x30 returns the handler address of the lowest-numbered slot that meets all of these conditions: it is enabled, its source is set in the normal-line status, and its number is below the current in-service priority. A slot whose source is routed to the fast line, or whose enable bit is 0, never matches.
- R8: When no slot matches, a read of 0x30 returns the default address held at 0x34 and leaves the in-service state unchanged.
- R9: A matching read of 0x30 makes that slot the current in-service priority, so that only lower-numbered slots can match until it is acknowledged.
- R10: A write of any value to 0x30 ends the innermost service and restores the previous priority. Repeated read/acknowledge pairs drain every nested level. An acknowledge with nothing in service has no effect.
- R11: Reads of 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the cell code in bits 7:0, with bits 31:8 zero. Bits 19:12 of the assembled code hold the vendor code.
- R12: Bit 0 of the protection register (0x20) and bit 0 of the test control register (0x300) store and read back the written value, and changing them has no effect on interrupt status.
- R13: Unmapped offsets read zero, and writes to read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_in | input | 32 | Level-sensitive interrupt source inputs |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The hardest condition to reach is a deep nest: several services are in flight and a lower-priority source is still pending behind them. Reaching it requires the in-service stack to be built up in order of rising priority, which the ports cannot do directly. The stimulus therefore raises software requests one at a time, issuing a vector read after each, from slot 12 through slot 7 to slot 3. It then raises slot 10 and confirms that the default address comes back. Finally it clears each source and acknowledges it, and checks that slot 10 wins exactly when the priority has dropped back to slot 12.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW      = 10;
  localparam int CTRL_EN_BIT = 5;
  localparam int ID_BYTES    = 4;

  localparam logic [REG_AW-1:0] W_IRQ_STAT  = 10'd0;
  localparam logic [REG_AW-1:0] W_FIQ_STAT  = 10'd1;
  localparam logic [REG_AW-1:0] W_RAW       = 10'd2;
  localparam logic [REG_AW-1:0] W_SELECT    = 10'd3;
  localparam logic [REG_AW-1:0] W_EN_SET    = 10'd4;
  localparam logic [REG_AW-1:0] W_EN_CLR    = 10'd5;
  localparam logic [REG_AW-1:0] W_SOFT_SET  = 10'd6;
  localparam logic [REG_AW-1:0] W_SOFT_CLR  = 10'd7;
  localparam logic [REG_AW-1:0] W_PROT      = 10'd8;
  localparam logic [REG_AW-1:0] W_CUR_VEC   = 10'd12;
  localparam logic [REG_AW-1:0] W_DEF_VEC   = 10'd13;
  localparam logic [REG_AW-1:0] W_SLOT_ADDR = 10'd64;
  localparam logic [REG_AW-1:0] W_SLOT_CTRL = 10'd128;
  localparam logic [REG_AW-1:0] W_TEST      = 10'd192;
  localparam logic [REG_AW-1:0] W_ID0       = 10'd1016;
endpackage

// File: rtl/vic_src_regs.sv
module vic_src_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [REG_AW-1:0]  waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] sel_q,
  output logic [NUM_SRC-1:0] soft_q,
  output logic [NUM_SRC-1:0] raw,
  output logic [NUM_SRC-1:0] irq_stat,
  output logic [NUM_SRC-1:0] fiq_stat,
  output logic               prot_q,
  output logic               test_q
);
  logic [NUM_SRC-1:0] en_d, sel_d, soft_d, wbits;
  logic               prot_d, test_d;

  assign wbits = wdata[NUM_SRC-1:0];

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    soft_d = soft_q;
    prot_d = prot_q;
    test_d = test_q;
    case (waddr)
      W_SELECT:   sel_d  = wbits;
      W_EN_SET:   en_d   = en_q | wbits;
      W_EN_CLR:   en_d   = en_q & ~wbits;
      W_SOFT_SET: soft_d = soft_q | wbits;
      W_SOFT_CLR: soft_d = soft_q & ~wbits;
      W_PROT:     prot_d = wdata[0];
      W_TEST:     test_d = wdata[0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      sel_q  <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
      test_q <= 1'b0;
    end else if (wr_stb) begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      soft_q <= soft_d;
      prot_q <= prot_d;
      test_q <= test_d;
    end
  end

  assign raw      = src_in | soft_q;
  assign irq_stat = raw & en_q & ~sel_q;
  assign fiq_stat = raw & en_q & sel_q;
endmodule

// File: rtl/vic_slot_bank.sv
module vic_slot_bank
  import vic_pkg::*;
#(
  parameter int NUM_SLOT = 16,
  parameter int NUM_SRC  = 32,
  parameter int DATA_W   = 32,
  localparam int SLOT_W  = $clog2(NUM_SLOT),
  localparam int SRC_W   = $clog2(NUM_SRC),
  localparam int PRI_W   = SLOT_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_stb,
  input  logic [REG_AW-1:0]                waddr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [NUM_SRC-1:0]               irq_stat,
  input  logic [PRI_W-1:0]                 cur_pri,
  output logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_addr,
  output logic [NUM_SLOT-1:0]              slot_en,
  output logic [NUM_SLOT-1:0][SRC_W-1:0]   slot_src,
  output logic                             hit,
  output logic [SLOT_W-1:0]                hit_idx,
  output logic [DATA_W-1:0]                hit_addr
);
  logic [NUM_SLOT-1:0] slot_match;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    logic addr_ld, ctrl_ld;
    assign addr_ld = wr_stb && (waddr == W_SLOT_ADDR + REG_AW'(i));
    assign ctrl_ld = wr_stb && (waddr == W_SLOT_CTRL + REG_AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_addr[i] <= '0;
      end else if (addr_ld) begin
        slot_addr[i] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_en[i]  <= 1'b0;
        slot_src[i] <= '0;
      end else if (ctrl_ld) begin
        slot_en[i]  <= wdata[CTRL_EN_BIT];
        slot_src[i] <= wdata[SRC_W-1:0];
      end
    end

    assign slot_match[i] = slot_en[i] && irq_stat[slot_src[i]] &&
                           (PRI_W'(i) < cur_pri);
  end

  always_comb begin
    hit_idx = '0;
    for (int j = NUM_SLOT - 1; j >= 0; j--) begin
      if (slot_match[j]) hit_idx = SLOT_W'(j);
    end
  end

  assign hit      = |slot_match;
  assign hit_addr = slot_addr[hit_idx];
endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
  parameter int DEPTH    = 17,
  parameter int PRI_W    = 5,
  parameter int IDLE_PRI = 16,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PRI_W-1:0] push_pri,
  input  logic             pop,
  output logic [PRI_W-1:0] cur_pri,
  output logic [CNT_W-1:0] cnt_q
);
  logic [DEPTH-1:0][PRI_W-1:0] mem_q;
  logic [CNT_W-1:0]            cnt_d, top;
  logic                        do_push, do_pop;

  assign do_push = push && (cnt_q < CNT_W'(DEPTH));
  assign do_pop  = pop && !push && (cnt_q != '0);
  assign top     = cnt_q - CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_push || do_pop) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (do_push) begin
      mem_q[cnt_q] <= push_pri;
    end
  end

  assign cur_pri = (cnt_q == '0) ? PRI_W'(IDLE_PRI) : mem_q[top];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          NUM_SLOT = 16,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] CELL_ID  = 32'h0005_A1C3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_wr,
  input  logic [REG_AW-1:0]  bus_waddr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out,
  output logic               fiq_out
);
  localparam int SLOT_W      = $clog2(NUM_SLOT);
  localparam int SRC_W       = $clog2(NUM_SRC);
  localparam int PRI_W       = SLOT_W + 1;
  localparam int STACK_DEPTH = NUM_SLOT + 1;
  localparam int CNT_W       = $clog2(STACK_DEPTH + 1);

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic wr_stb, rd_stb, vec_rd, vec_ack;
  assign wr_stb  = bus_req && bus_wr;
  assign rd_stb  = bus_req && !bus_wr;
  assign vec_rd  = rd_stb && (bus_waddr == W_CUR_VEC);
  assign vec_ack = wr_stb && (bus_waddr == W_CUR_VEC);

  logic [NUM_SRC-1:0] en_q, sel_q, soft_q, raw, irq_stat, fiq_stat;
  logic               prot_q, test_q;

  vic_src_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_src (
    .clk(clk), .rst_n(rst_core_n), .wr_stb(wr_stb), .waddr(bus_waddr),
    .wdata(bus_wdata), .src_in(src_in), .en_q(en_q), .sel_q(sel_q),
    .soft_q(soft_q), .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat),
    .prot_q(prot_q), .test_q(test_q)
  );

  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr;
  logic [NUM_SLOT-1:0]             slot_en;
  logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_src;
  logic                            vec_hit;
  logic [SLOT_W-1:0]               hit_idx;
  logic [DATA_W-1:0]               hit_addr;
  logic [PRI_W-1:0]                cur_pri;
  logic [CNT_W-1:0]                stk_cnt;

  vic_slot_bank #(.NUM_SLOT(NUM_SLOT), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_stb(wr_stb), .waddr(bus_waddr),
    .wdata(bus_wdata), .irq_stat(irq_stat), .cur_pri(cur_pri),
    .slot_addr(slot_addr), .slot_en(slot_en), .slot_src(slot_src),
    .hit(vec_hit), .hit_idx(hit_idx), .hit_addr(hit_addr)
  );

  vic_prio_stack #(.DEPTH(STACK_DEPTH), .PRI_W(PRI_W), .IDLE_PRI(NUM_SLOT)) u_stack (
    .clk(clk), .rst_n(rst_core_n), .push(vec_rd && vec_hit),
    .push_pri(PRI_W'(hit_idx)), .pop(vec_ack), .cur_pri(cur_pri), .cnt_q(stk_cnt)
  );

  logic [DATA_W-1:0] def_addr_q;
  logic              def_ld;
  assign def_ld = wr_stb && (bus_waddr == W_DEF_VEC);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  def_addr_q <= '0;
    else if (def_ld)  def_addr_q <= bus_wdata;
  end

  logic [REG_AW-1:0] slot_off, ctrl_off, id_off;
  logic [SLOT_W-1:0] a_idx, c_idx;
  logic [1:0]        id_sel;
  assign slot_off = bus_waddr - W_SLOT_ADDR;
  assign ctrl_off = bus_waddr - W_SLOT_CTRL;
  assign id_off   = bus_waddr - W_ID0;
  assign a_idx    = slot_off[SLOT_W-1:0];
  assign c_idx    = ctrl_off[SLOT_W-1:0];
  assign id_sel   = id_off[1:0];

  always_comb begin
    bus_rdata = '0;
    case (bus_waddr)
      W_IRQ_STAT: bus_rdata = DATA_W'(irq_stat);
      W_FIQ_STAT: bus_rdata = DATA_W'(fiq_stat);
      W_RAW:      bus_rdata = DATA_W'(raw);
      W_SELECT:   bus_rdata = DATA_W'(sel_q);
      W_EN_SET:   bus_rdata = DATA_W'(en_q);
      W_SOFT_SET: bus_rdata = DATA_W'(soft_q);
      W_PROT:     bus_rdata = DATA_W'(prot_q);
      W_TEST:     bus_rdata = DATA_W'(test_q);
      W_CUR_VEC:  bus_rdata = vec_hit ? hit_addr : def_addr_q;
      W_DEF_VEC:  bus_rdata = def_addr_q;
      default: begin
        if (slot_off < REG_AW'(NUM_SLOT)) begin
          bus_rdata = slot_addr[a_idx];
        end else if (ctrl_off < REG_AW'(NUM_SLOT)) begin
          bus_rdata = (DATA_W'(slot_en[c_idx]) << CTRL_EN_BIT) |
                      DATA_W'(slot_src[c_idx]);
        end else if (id_off < REG_AW'(ID_BYTES)) begin
          bus_rdata = DATA_W'(CELL_ID[id_sel*8 +: 8]);
        end
      end
    endcase
  end

  assign irq_out = |irq_stat;
  assign fiq_out = |fiq_stat;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk
  import vic_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DEPTH = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_waddr,
  input logic [31:0]       bus_rdata,
  input logic              irq_out,
  input logic              fiq_out,
  input logic              vec_hit,
  input logic [CNT_W-1:0]  stk_cnt
);
  logic rd_vec, ack_vec;
  assign rd_vec  = bus_req && !bus_wr && (bus_waddr == W_CUR_VEC);
  assign ack_vec = bus_req && bus_wr && (bus_waddr == W_CUR_VEC);

  assert_irq_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_waddr == W_IRQ_STAT) |-> ((bus_rdata != '0) == irq_out));

  assert_fiq_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_waddr == W_FIQ_STAT) |-> ((bus_rdata != '0) == fiq_out));

  assert_push_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && vec_hit) |=> (stk_cnt == $past(stk_cnt) + 1'b1));

  assert_no_push_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && !vec_hit) |=> $stable(stk_cnt));

  assert_ack_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec && stk_cnt != '0) |=> (stk_cnt == $past(stk_cnt) - 1'b1));

  assert_stack_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_vec || ack_vec) |=> $stable(stk_cnt));

  assert_stack_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CNT_W'(DEPTH));

  assert_id_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_waddr >= W_ID0 && bus_waddr < W_ID0 + 10'd4)
      |-> (bus_rdata[31:8] == '0));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.CNT_W(CNT_W), .DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_waddr(bus_waddr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .fiq_out(fiq_out), .vec_hit(vec_hit), .stk_cnt(stk_cnt)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam logic [31:0] EXP_ID  = 32'h0005_A1C3;
  localparam logic [31:0] DEF_VEC = 32'hDEAD_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [9:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] src = '0;
  logic        irq_o, fiq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl #(.CELL_ID(EXP_ID)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr), .bus_waddr(waddr),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src),
    .irq_out(irq_o), .fiq_out(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; waddr = a[11:2]; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; waddr = a[11:2];
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  function automatic logic [31:0] slot_vec(input int k);
    return 32'h8000_0000 + 32'(k) * 32'h40;
  endfunction

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] id_val;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rreg(12'h000, d); chk("R1 irq status", d, 0);
    rreg(12'h010, d); chk("R1 enable", d, 0);
    rreg(12'h00C, d); chk("R1 select", d, 0);
    rreg(12'h018, d); chk("R1 soft", d, 0);
    rreg(12'h030, d); chk("R1 vector", d, 0);
    rreg(12'h104, d); chk("R1 slot addr", d, 0);
    rreg(12'h300, d); chk("R1 test ctrl", d, 0);
    chk("R1 lines", {30'b0, irq_o, fiq_o}, 0);

    // R11 identification
    id_val = '0;
    for (int k = 0; k < 4; k++) begin
      rreg(12'hFE0 + 12'(4 * k), d);
      chk("R11 id byte", d, {24'b0, EXP_ID[8*k +: 8]});
      id_val[8*k +: 8] = d[7:0];
    end
    chk("R11 vendor", {24'b0, id_val[19:12]}, 32'h5A);

    // R2..R5 sweep over every source
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      logic        f;
      b = 32'h1 << i;
      f = i[0];
      wreg(12'h018, b);
      rreg(12'h008, d); chk("R2 raw soft", d, b);
      rreg(12'h018, d); chk("R5 soft set", d, b);
      wreg(12'h010, b);
      rreg(12'h010, d); chk("R4 enable set", d, b);
      wreg(12'h00C, f ? b : 32'h0);
      rreg(12'h000, d); chk("R3 irq status", d, f ? 32'h0 : b);
      rreg(12'h004, d); chk("R3 fiq status", d, f ? b : 32'h0);
      chk("R3 lines", {30'b0, irq_o, fiq_o}, {30'b0, !f, f});
      wreg(12'h01C, b);
      rreg(12'h018, d); chk("R5 soft clear", d, 0);
      wreg(12'h014, b);
      rreg(12'h010, d); chk("R4 enable clear", d, 0);
      wreg(12'h00C, 0);
    end

    // R2/R3/R4 with hardware inputs and mixed patterns
    src = 32'hA5A5_0F0F;
    wreg(12'h010, 32'h00FF_FF00);
    wreg(12'h00C, 32'hF0F0_F0F0);
    rreg(12'h008, d); chk("R2 raw hw", d, 32'hA5A5_0F0F);
    rreg(12'h000, d); chk("R3 irq mix", d, 32'hA5A5_0F0F & 32'h00FF_FF00 & ~32'hF0F0_F0F0);
    rreg(12'h004, d); chk("R3 fiq mix", d, 32'hA5A5_0F0F & 32'h00FF_FF00 & 32'hF0F0_F0F0);
    wreg(12'h014, 32'h0000_0100);
    rreg(12'h010, d); chk("R4 single clear", d, 32'h00FF_FE00);
    wreg(12'h010, 32'h0);
    rreg(12'h010, d); chk("R4 zero set", d, 32'h00FF_FE00);
    wreg(12'h018, 32'h0000_00F0);
    rreg(12'h008, d); chk("R2 raw or", d, 32'hA5A5_0FFF);
    wreg(12'h01C, 32'h0);
    rreg(12'h018, d); chk("R5 zero clear", d, 32'h0000_00F0);

    // R12 protect/test, R13 unmapped and read-only
    rreg(12'h000, d);
    wreg(12'h020, 32'hFFFF_FFFF);
    wreg(12'h300, 32'h1);
    rreg(12'h020, d); chk("R12 protect", d, 1);
    rreg(12'h300, d); chk("R12 test ctrl", d, 1);
    rreg(12'h000, d); chk("R12 no effect", d, 32'hA5A5_0F0F & 32'h00FF_FE00 & ~32'hF0F0_F0F0 | (32'h0000_00F0 & 32'h00FF_FE00 & ~32'hF0F0_F0F0));
    wreg(12'h020, 0); wreg(12'h300, 0);
    rreg(12'h040, d); chk("R13 unmapped 40", d, 0);
    rreg(12'h02C, d); chk("R13 unmapped 2C", d, 0);
    rreg(12'hFF0, d); chk("R13 unmapped FF0", d, 0);
    wreg(12'h000, 32'hFFFF_FFFF);
    wreg(12'h008, 32'hFFFF_FFFF);
    rreg(12'h010, d); chk("R13 ro write", d, 32'h00FF_FE00);

    // clean up
    src = '0;
    wreg(12'h014, 32'hFFFF_FFFF);
    wreg(12'h01C, 32'hFFFF_FFFF);
    wreg(12'h00C, 0);

    // R6 program slots: slot k -> source 31-k
    wreg(12'h034, DEF_VEC);
    for (int k = 0; k < 16; k++) begin
      wreg(12'h100 + 12'(4 * k), slot_vec(k));
      wreg(12'h200 + 12'(4 * k), 32'hFFFF_FFC0 | 32'h20 | 32'(31 - k));
    end
    for (int k = 0; k < 16; k++) begin
      rreg(12'h100 + 12'(4 * k), d); chk("R6 slot addr", d, slot_vec(k));
      rreg(12'h200 + 12'(4 * k), d); chk("R6 slot ctrl", d, 32'h20 | 32'(31 - k));
    end
    wreg(12'h010, 32'hFFFF_FFFF);

    // R8 nothing active
    rreg(12'h030, d); chk("R8 default", d, DEF_VEC);

    // R7/R9/R10 each slot alone
    for (int k = 0; k < 16; k++) begin
      wreg(12'h018, 32'h1 << (31 - k));
      rreg(12'h030, d); chk("R7 slot match", d, slot_vec(k));
      rreg(12'h030, d); chk("R9 no self preempt", d, DEF_VEC);
      wreg(12'h01C, 32'h1 << (31 - k));
      wreg(12'h030, 32'h0);
    end
    // R10 ack on empty stack is harmless
    wreg(12'h030, 32'h1234);
    wreg(12'h018, 32'h1 << 16);
    rreg(12'h030, d); chk("R10 empty ack", d, slot_vec(15));
    wreg(12'h01C, 32'h1 << 16);
    wreg(12'h030, 0);

    // R7 priority: lowest-numbered wins when several active
    wreg(12'h018, (32'h1 << 22) | (32'h1 << 27) | (32'h1 << 18));
    rreg(12'h030, d); chk("R7 priority", d, slot_vec(4));
    wreg(12'h01C, 32'hFFFF_FFFF);
    wreg(12'h030, 0);

    // R9/R10 nesting: slots 12, 7, 3 then pending 10
    wreg(12'h018, 32'h1 << 19);
    rreg(12'h030, d); chk("R9 nest 12", d, slot_vec(12));
    wreg(12'h018, 32'h1 << 24);
    rreg(12'h030, d); chk("R9 nest 7", d, slot_vec(7));
    wreg(12'h018, 32'h1 << 28);
    rreg(12'h030, d); chk("R9 nest 3", d, slot_vec(3));
    wreg(12'h018, 32'h1 << 21);
    rreg(12'h030, d); chk("R9 blocked 10 at 3", d, DEF_VEC);
    wreg(12'h01C, 32'h1 << 28);
    wreg(12'h030, 0);
    rreg(12'h030, d); chk("R10 blocked 10 at 7", d, DEF_VEC);
    wreg(12'h01C, 32'h1 << 24);
    wreg(12'h030, 0);
    rreg(12'h030, d); chk("R10 preempt 10 at 12", d, slot_vec(10));
    wreg(12'h01C, 32'h1 << 21);
    wreg(12'h030, 0);
    rreg(12'h030, d); chk("R10 back at 12", d, DEF_VEC);
    wreg(12'h01C, 32'h1 << 19);
    wreg(12'h030, 0);
    wreg(12'h018, 32'h1 << 16);
    rreg(12'h030, d); chk("R10 drained", d, slot_vec(15));
    wreg(12'h01C, 32'h1 << 16);
    wreg(12'h030, 0);

    // R7 fast-routed source never matches
    wreg(12'h00C, 32'h1 << 31);
    wreg(12'h018, 32'h1 << 31);
    rreg(12'h030, d); chk("R7 fiq excluded", d, DEF_VEC);
    chk("R7 fiq line", {30'b0, irq_o, fiq_o}, 32'h1);
    wreg(12'h00C, 0);
    rreg(12'h030, d); chk("R7 irq routed", d, slot_vec(0));
    wreg(12'h01C, 32'h1 << 31);
    wreg(12'h030, 0);

    // R7 disabled slot never matches (hardware input drives source)
    wreg(12'h214, 32'(31 - 5));
    src = 32'h1 << 26;
    rreg(12'h030, d); chk("R7 slot disabled", d, DEF_VEC);
    wreg(12'h214, 32'h20 | 32'(31 - 5));
    rreg(12'h030, d); chk("R7 slot reenabled", d, slot_vec(5));
    src = '0;
    wreg(12'h030, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule